// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides where a branch-conditional instruction goes. It keeps two architectural registers, a loop count register and a return link register. For each branch that is presented it runs two tests: one on the counter and one on a single bit of the condition register. A 5-bit option field chooses which tests apply and how each one passes. If the branch is not taken, the next address is the address that follows in sequence.

A branch is presented for one clock cycle with `valid_i` high. The block resolves it at that clock edge. At the same edge it updates the count and link registers, and it registers the next address and the taken flag. Those outputs hold their values until the next valid branch. The branch kind selects the destination. It can be an immediate target (relative), the link register, or the count register. A fourth kind is an unconditional call that always goes to the immediate target and records a return address.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the count and link registers, `next_pc_o` and `taken_o` all become zero.
- R2: `next_pc_o` and `taken_o` change only at the clock edge where `valid_i` is high. They hold their values while `valid_i` is low.
- R3: For kinds relative (`kind_i`=0) and to-link (`kind_i`=1), the count register is decremented by 1 when option bit 2 (`opt_i[2]`, value 0x04) is clear. The counter test then uses the decremented value. Decrementing from zero wraps to all ones.
- R4: The counter test passes when `opt_i[2]` is set. Otherwise it passes on a zero counter when `opt_i[1]` (0x02) is set, or on a nonzero counter when `opt_i[1]` is clear.
- R5: The condition test passes when `opt_i[4]` (0x10) is set. Otherwise the selected condition bit must equal `opt_i[3]` (0x08). Index `idx_i` selects 4-bit field `idx_i/4` and offset `idx_i%4` inside it. Field 0 is the most significant nibble and offset 0 is the field's top bit, so the selected bit is `cr_i[31-idx_i]`.
- R6: A conditional branch is taken only if both tests pass. Otherwise `taken_o` is 0 and `next_pc_o` is `pc_i + 4`.
- R7: For kind to-link (`kind_i`=1), the target is the link register value from before the edge, with its two low bits cleared.
- R8: For kind to-count (`kind_i`=2), the target is the count register value from before the edge, with its two low bits cleared. The counter is not decremented and the counter test always passes.
- R9: Kinds to-count (2) and unconditional-with-link (3) write `pc_i + 4` into the link register at the resolving edge, whether or not the branch is taken.
- R10: Kind unconditional-with-link (3) is always taken to `target_i`. The options and the condition bit are ignored and the counter is not changed.
- R11: For kind relative (`kind_i`=0), a taken branch goes to `target_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A branch is presented this cycle |
| kind_i | input | 2 | Branch kind: 0 relative, 1 to-link, 2 to-count, 3 unconditional with link |
| pc_i | input | 32 | Address of the branch instruction |
| target_i | input | 32 | Immediate target address |
| opt_i | input | 5 | Branch option field (test selection) |
| idx_i | input | 5 | Condition-bit index |
| cr_i | input | 32 | Condition register |
| next_pc_o | output | 32 | Resolved next instruction address |
| taken_o | output | 1 | Branch was taken |

## Verification
The assertions assume that `valid_i`, `kind_i` and `pc_i` are free of X at each edge where a branch is presented. They also assume that `pc_i + 4` is the fall-through address without any wrap handling. The stimulus drives every input on the falling edge and raises `valid_i` for exactly one rising edge per branch. It keeps `pc_i` well below the top of the address space. The counter starts at zero after reset and is never loaded, so the stimulus reaches the nonzero side of the counter test by wrapping the counter downwards.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int OPT_W  = 5;
    localparam int IDX_W  = 5;
    localparam int CR_W   = 32;
    localparam int FLD_W  = 4;

    // option bit positions (behavioural: each bit selects a test mode)
    localparam int OPT_SKIP_COND = 4;
    localparam int OPT_WANT_BIT  = 3;
    localparam int OPT_KEEP_CTR  = 2;
    localparam int OPT_ON_ZERO   = 1;

    typedef enum logic [1:0] {
        BK_REL         = 2'd0,
        BK_TO_LINK     = 2'd1,
        BK_TO_COUNT    = 2'd2,
        BK_UNCOND_LINK = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic ctr_ok;
        logic cond_ok;
        logic dec_en;
    } br_test_t;

    // field idx/4, offset idx%4, offset 0 is the field's top bit
    function automatic logic pick_cr_bit(logic [CR_W-1:0] cr, logic [IDX_W-1:0] idx);
        int unsigned fld;
        int unsigned off;
        fld = int'(idx) / FLD_W;
        off = int'(idx) % FLD_W;
        return cr[CR_W - 1 - (fld * FLD_W + off)];
    endfunction

endpackage

// File: rtl/bru_tests.sv
module bru_tests
    import bru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e               kind,
    input  logic [OPT_W-1:0]       opt,
    input  logic [IDX_W-1:0]       idx,
    input  logic [CR_W-1:0]        cr,
    input  logic [XLEN-1:0]        ctr_cur,
    output br_test_t               res,
    output logic [XLEN-1:0]        ctr_new
);
    logic cond_kind;
    logic sel_bit;

    always_comb begin
        cond_kind   = (kind == BK_REL) || (kind == BK_TO_LINK);
        res.dec_en  = cond_kind && !opt[OPT_KEEP_CTR];
        ctr_new     = res.dec_en ? (ctr_cur - XLEN'(1)) : ctr_cur;

        if (!res.dec_en)
            res.ctr_ok = 1'b1;
        else if (opt[OPT_ON_ZERO])
            res.ctr_ok = (ctr_new == '0);
        else
            res.ctr_ok = (ctr_new != '0);

        sel_bit     = pick_cr_bit(cr, idx);
        res.cond_ok = opt[OPT_SKIP_COND] || (sel_bit == opt[OPT_WANT_BIT]);
    end
endmodule

// File: rtl/bru_spr_regs.sv
module bru_spr_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctr_we,
    input  logic [XLEN-1:0] ctr_d,
    input  logic            lr_we,
    input  logic [XLEN-1:0] lr_d,
    output logic [XLEN-1:0] ctr_q,
    output logic [XLEN-1:0] lr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
            lr_q  <= '0;
        end else begin
            if (ctr_we) ctr_q <= ctr_d;
            if (lr_we)  lr_q  <= lr_d;
        end
    end

    // R1
    spr_reset_chk: assert property (@(posedge clk) rst |=> (ctr_q == '0 && lr_q == '0));
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  br_kind_e        kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] tgt,
    input  logic [XLEN-1:0] ctr_cur,
    input  logic [XLEN-1:0] lr_cur,
    input  logic            take,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] seq_pc
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'((1 << ALIGN_BITS) - 1);
    localparam logic [XLEN-1:0] STEP       = XLEN'(1 << ALIGN_BITS);

    logic [XLEN-1:0] jump_pc;

    always_comb begin
        seq_pc = pc + STEP;
        unique case (kind)
            BK_TO_LINK:  jump_pc = lr_cur & ALIGN_MASK;
            BK_TO_COUNT: jump_pc = ctr_cur & ALIGN_MASK;
            default:     jump_pc = tgt;
        endcase
        next_pc = take ? jump_pc : seq_pc;
    end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_i,
    input  logic [1:0]      kind_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] target_i,
    input  logic [4:0]      opt_i,
    input  logic [4:0]      idx_i,
    input  logic [31:0]     cr_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            taken_o
);
    br_kind_e        kind;
    br_test_t        tst;
    logic [XLEN-1:0] ctr_q, lr_q, ctr_new, nxt, seq;
    logic            take, link_wr;

    assign kind = br_kind_e'(kind_i);

    bru_tests #(.XLEN(XLEN)) u_tests (
        .kind(kind), .opt(opt_i), .idx(idx_i), .cr(cr_i),
        .ctr_cur(ctr_q), .res(tst), .ctr_new(ctr_new)
    );

    always_comb begin
        take    = (kind == BK_UNCOND_LINK) || (tst.ctr_ok && tst.cond_ok);
        link_wr = (kind == BK_TO_COUNT) || (kind == BK_UNCOND_LINK);
    end

    bru_target #(.XLEN(XLEN), .ALIGN_BITS(2)) u_target (
        .kind(kind), .pc(pc_i), .tgt(target_i), .ctr_cur(ctr_q),
        .lr_cur(lr_q), .take(take), .next_pc(nxt), .seq_pc(seq)
    );

    bru_spr_regs #(.XLEN(XLEN)) u_regs (
        .clk(clk), .rst(rst),
        .ctr_we(valid_i && tst.dec_en), .ctr_d(ctr_new),
        .lr_we(valid_i && link_wr), .lr_d(seq),
        .ctr_q(ctr_q), .lr_q(lr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o <= '0;
            taken_o   <= 1'b0;
        end else if (valid_i) begin
            next_pc_o <= nxt;
            taken_o   <= take;
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(next_pc_o) && $stable(taken_o)));
    // R6
    fallthru_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (taken_o || next_pc_o == $past(pc_i) + XLEN'(4)));
    // R10
    uncond_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 2'd3) |=> (taken_o && next_pc_o == $past(target_i)));
    // R9
    link_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i[1]) |=> (lr_q == $past(pc_i) + XLEN'(4)));
    // R8
    ctr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i[1]) |=> $stable(ctr_q));
    // R7
    align_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (kind_i == 2'd1 || kind_i == 2'd2)) |=> (!taken_o || next_pc_o[1:0] == 2'b00));
endmodule

// File: tb/test_branch_resolve_unit.sv
module test_branch_resolve_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [1:0]  kind_i;
    logic [31:0] pc_i, target_i, cr_i;
    logic [4:0]  opt_i, idx_i;
    logic [31:0] next_pc_o;
    logic        taken_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_ctr;
    logic [31:0] exp_lr;

    always #10 clk = ~clk;

    branch_resolve_unit i_branch_resolve_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .kind_i(kind_i),
        .pc_i(pc_i), .target_i(target_i), .opt_i(opt_i), .idx_i(idx_i),
        .cr_i(cr_i), .next_pc_o(next_pc_o), .taken_o(taken_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] k, logic [31:0] pc, logic [31:0] tgt,
                         logic [4:0] opt, logic [4:0] idx, logic [31:0] cr);
        @(negedge clk);
        valid_i = 1'b1; kind_i = k; pc_i = pc; target_i = tgt;
        opt_i = opt; idx_i = idx; cr_i = cr;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic expect_br(string req, logic tk, logic [31:0] nxt);
        check(req, {31'd0, taken_o}, {31'd0, tk});
        check(req, next_pc_o, nxt);
    endtask

    task automatic t_reset;
        rst = 1'b1; valid_i = 1'b0; kind_i = 0; pc_i = 0; target_i = 0;
        opt_i = 0; idx_i = 0; cr_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_br("R1", 1'b0, 32'h0);
        exp_ctr = 0; exp_lr = 0;
        // R1: both registers zero, seen through the to-count/to-link targets
        issue(2'd2, 32'h100, 0, 5'h14, 0, 0);
        expect_br("R1", 1'b1, 32'h0);
        exp_lr = 32'h104;
    endtask

    task automatic t_link_target;
        issue(2'd2, 32'h203, 0, 5'h14, 0, 0);   // lr <- 0x207
        expect_br("R8", 1'b1, exp_ctr & ~32'h3);
        exp_lr = 32'h207;
        issue(2'd1, 32'h300, 32'hDEAD0000, 5'h14, 0, 0);
        expect_br("R7", 1'b1, 32'h204);
    endtask

    task automatic t_hold;
        repeat (4) @(negedge clk);
        expect_br("R2", 1'b1, 32'h204);
    endtask

    task automatic t_counter;
        // decrement 0 -> ffffffff, branch-on-zero fails
        issue(2'd0, 32'h500, 32'h1000, 5'h12, 0, 0);
        exp_ctr = exp_ctr - 1;
        expect_br("R4", 1'b0, 32'h504);
        issue(2'd2, 32'h600, 0, 5'h14, 0, 0);
        expect_br("R3", 1'b1, 32'hFFFFFFFC);
        exp_lr = 32'h604;
        // decrement to fffffffe, nonzero passes
        issue(2'd0, 32'h700, 32'h2000, 5'h10, 0, 0);
        exp_ctr = exp_ctr - 1;
        expect_br("R4", 1'b1, 32'h2000);
        // no-decrement option: counter test passes, counter unchanged
        issue(2'd0, 32'h710, 32'h2100, 5'h16, 0, 0);
        expect_br("R4", 1'b1, 32'h2100);
        issue(2'd2, 32'h720, 0, 5'h14, 0, 0);
        expect_br("R3", 1'b1, exp_ctr & ~32'h3);
        exp_lr = 32'h724;
    endtask

    task automatic t_condition;
        issue(2'd0, 32'h800, 32'h3000, 5'h0C, 5'd0, 32'h8000_0000);
        expect_br("R5", 1'b1, 32'h3000);
        issue(2'd0, 32'h800, 32'h3000, 5'h0C, 5'd1, 32'h8000_0000);
        expect_br("R5", 1'b0, 32'h804);
        issue(2'd0, 32'h810, 32'h3100, 5'h04, 5'd1, 32'h8000_0000);
        expect_br("R5", 1'b1, 32'h3100);
        issue(2'd0, 32'h820, 32'h3200, 5'h0C, 5'd31, 32'h0000_0001);
        expect_br("R5", 1'b1, 32'h3200);
        issue(2'd0, 32'h830, 32'h3300, 5'h0C, 5'd6, 32'h0200_0000);
        expect_br("R5", 1'b1, 32'h3300);
        issue(2'd0, 32'h840, 32'h3400, 5'h0C, 5'd7, 32'h0200_0000);
        expect_br("R5", 1'b0, 32'h844);
        // R11: relative target passes through unaligned
        issue(2'd0, 32'h850, 32'h3403, 5'h14, 5'd0, 0);
        expect_br("R11", 1'b1, 32'h3403);
    endtask

    task automatic t_both;
        // counter passes (decrement, nonzero), condition fails
        issue(2'd0, 32'h900, 32'h5000, 5'h08, 5'd2, 32'h0);
        exp_ctr = exp_ctr - 1;
        expect_br("R6", 1'b0, 32'h904);
        // condition passes, counter fails (branch on zero while nonzero)
        issue(2'd1, 32'h910, 32'h0, 5'h1A, 5'd2, 32'h0);
        exp_ctr = exp_ctr - 1;
        expect_br("R6", 1'b0, 32'h914);
        issue(2'd2, 32'h920, 0, 5'h14, 0, 0);
        expect_br("R3", 1'b1, exp_ctr & ~32'h3);
        exp_lr = 32'h924;
    endtask

    task automatic t_link_write;
        // to-count, not taken (condition fails), link still written
        issue(2'd2, 32'hA00, 0, 5'h0C, 5'd0, 32'h0);
        expect_br("R9", 1'b0, 32'hA04);
        issue(2'd1, 32'hA10, 0, 5'h14, 0, 0);
        expect_br("R9", 1'b1, 32'hA04);
    endtask

    task automatic t_uncond;
        issue(2'd3, 32'hB00, 32'h7000, 5'h00, 5'd0, 32'h0);
        expect_br("R10", 1'b1, 32'h7000);
        issue(2'd1, 32'hB10, 0, 5'h14, 0, 0);
        expect_br("R10", 1'b1, 32'hB04);
        issue(2'd2, 32'hB20, 0, 5'h14, 0, 0);
        expect_br("R10", 1'b1, exp_ctr & ~32'h3);
    endtask

    initial begin
        t_reset();
        t_link_target();
        t_hold();
        t_counter();
        t_condition();
        t_both();
        t_link_write();
        t_uncond();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule